// File: doc/BRIEF.md
# Locked 32-Pin GPIO Bank

This block is a bank of general-purpose pins controlled through a small register port. Every pin has its own configuration word. That word sets the direction, push-pull or open-drain drive, the output polarity, the source of the output value, a three-bit function index, the input-pad disable and an interrupt detection mode. Bank-wide registers collect the live pad inputs, a parallel output word, a lock word and the per-pin interrupt status.

Software writes a configuration word and the bank immediately drives `pad_oe`/`pad_do` for that pin. Peripherals outside the block see only the function index. Each pin raises its status bit from its detection mode: level-low, level-high, rising, falling, either edge, or off. The lock word can only be set. A locked pin's configuration and parallel output bit are frozen until reset.

The register port is single-cycle. A write is accepted on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current state.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every configuration word reads 0x00008040 (input pad off, detection off, bit 24 low whatever the pad is). The parallel output, lock and status registers read 0, and every `pad_oe` is 0.
- R2: A configuration write stores `bus_wdata[16:0]`. A read of it returns those 17 bits and bit 24 = pad input AND NOT bit 15. All other bits read 0.
- R3: With function index 0, direction bit 9 selects the drive. When bit 9 is 0, `pad_oe` and `pad_do` are 0. When bit 9 is 1 and bit 8 is 0 (push-pull), `pad_oe` is 1 and `pad_do` equals the pin value.
- R4: With bit 8 = 1 (open-drain), a pin value of 1 gives `pad_oe` = 0 and a value of 0 gives `pad_oe` = 1. `pad_do` is 0 in both cases.
- R5: The pin value is the source bit XOR bit 11. The source bit is config bit 16 when bit 10 is 0, and the pin's parallel-output bit when bit 10 is 1.
- R6: Bits [14:12] appear on `fn_sel[3*i+2:3*i]`. When they are nonzero, `pad_oe` and `pad_do` for that pin are 0.
- R7: The parallel input register reads, per pin, the live pad input gated by NOT bit 15.
- R8: A write to the lock register ORs `bus_wdata` into it. No write clears a lock bit; only reset does.
- R9: While a pin's lock bit is set, writes to its configuration word and to its parallel-output bit leave them unchanged. Other pins still take the write.
- R10: Detection code bits[7:4] = 0x0 (level-low) or 0x1 (level-high) makes the status bit equal to whether the enabled pad is at that level, as sampled one clock earlier. Writing 1 to the bit does not clear it.
- R11: Codes 0xD (rising), 0xE (falling) and 0xF (both) compare the pad with its value one clock earlier. A matching edge sets a sticky status bit, and writing 1 to that bit clears it.
- R12: Code 0x4 and every other code raise no new status but keep a pending bit until it is cleared. With the input pad disabled (bit 15 = 1), no mode raises status.
- R13: Addresses 0..31 hold the configuration words. Address 32 is parallel input (read-only), 33 parallel output, 34 lock and 35 status (write 1 to clear). Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pad input levels, synchronous to `clk` |
| pad_oe | output | 32 | Per-pin output enable |
| pad_do | output | 32 | Per-pin output data |
| fn_sel | output | 96 | Per-pin function index, three bits per pin |
| irq_stat | output | 32 | Per-pin interrupt status |

## Verification
The bound checker watches, on every cycle and for every pin, four invariants:
- An input-direction pin never enables its driver.
- An open-drain pin never drives a high.
- A pin handed to an alternate function is undriven.
- Lock bits never fall, and a locked configuration never moves.

It also checks that a pin in the off detection mode cannot gain a status bit. The bench scenarios are needed for the rest: the exact pin value under each source and polarity choice, the one-clock lag of level status, sticky edge capture with write-1-to-clear, the live pad bit in read data, and the partial masking of a parallel-output write by the lock word.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // stored width of a configuration word (bits 16:0)
    localparam int CTRL_W = 17;
    localparam logic [CTRL_W-1:0] CTRL_RST = 17'h08040;

    // configuration bit positions
    localparam int B_DET_LO = 4;
    localparam int B_OD     = 8;
    localparam int B_DIR    = 9;
    localparam int B_SRC    = 10;
    localparam int B_POL    = 11;
    localparam int B_FN_LO  = 12;
    localparam int B_PADOFF = 15;
    localparam int B_VAL    = 16;
    localparam int B_PADRD  = 24;

    // bank registers, offsets above the configuration words
    localparam int REG_PIN_IN = 0;
    localparam int REG_POUT   = 1;
    localparam int REG_LOCK   = 2;
    localparam int REG_STAT   = 3;

    typedef enum logic [3:0] {
        DET_LVL_LO = 4'h0,
        DET_LVL_HI = 4'h1,
        DET_OFF    = 4'h4,
        DET_RISE   = 4'hD,
        DET_FALL   = 4'hE,
        DET_BOTH   = 4'hF
    } det_mode_e;

endpackage

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
    input  logic       dir,
    input  logic       od,
    input  logic       src,
    input  logic       pol,
    input  logic       cval,
    input  logic       pout,
    input  logic [2:0] fn_in,
    output logic       oe,
    output logic       dout,
    output logic [2:0] fn
);
    logic val;
    logic gpio_out;

    always_comb begin
        fn       = fn_in;
        val      = (src ? pout : cval) ^ pol;
        gpio_out = (fn_in == 3'd0) && dir;
        oe       = 1'b0;
        dout     = 1'b0;
        if (gpio_out) begin
            if (od) begin
                oe = ~val;
            end else begin
                oe   = 1'b1;
                dout = val;
            end
        end
    end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_bank_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       pad_off,
    input  logic       pad,
    input  logic       pad_prev,
    input  logic       stat,
    input  logic       clr,
    output logic       live,
    output logic       stat_nxt
);
    logic en;
    logic rise;
    logic fall;
    logic kept;

    always_comb begin
        en   = ~pad_off;
        live = pad & en;
        rise = en & pad & ~pad_prev;
        fall = en & ~pad & pad_prev;
        kept = stat & ~clr;
        case (mode)
            DET_LVL_LO: stat_nxt = en & ~pad;
            DET_LVL_HI: stat_nxt = en & pad;
            DET_RISE:   stat_nxt = kept | rise;
            DET_FALL:   stat_nxt = kept | fall;
            DET_BOTH:   stat_nxt = kept | rise | fall;
            default:    stat_nxt = kept;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = $clog2(NPINS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_do,
    output logic [3*NPINS-1:0] fn_sel,
    output logic [NPINS-1:0]   irq_stat
);
    localparam int IW = AW - 1;

    typedef struct packed {
        logic [NPINS-1:0][CTRL_W-1:0] ctrl;
        logic [NPINS-1:0]             pout;
        logic [NPINS-1:0]             lock;
        logic [NPINS-1:0]             stat;
        logic [NPINS-1:0]             inq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NPINS-1:0] live;
    logic [NPINS-1:0] stat_nxt;
    logic [NPINS-1:0] clr;
    logic             sel_bank;
    logic [IW-1:0]    sel_idx;

    // views of the state for the bound checker
    logic [NPINS-1:0][CTRL_W-1:0] ctrl_v;
    logic [NPINS-1:0]             lock_v;

    assign sel_bank = bus_addr[AW-1];
    assign sel_idx  = bus_addr[IW-1:0];
    assign irq_stat = st_q.stat;
    assign ctrl_v   = st_q.ctrl;
    assign lock_v   = st_q.lock;

    assign clr = (bus_wr && sel_bank && (sel_idx == IW'(REG_STAT)))
               ? bus_wdata[NPINS-1:0] : '0;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_drive u_drv (
            .dir   (st_q.ctrl[g][B_DIR]),
            .od    (st_q.ctrl[g][B_OD]),
            .src   (st_q.ctrl[g][B_SRC]),
            .pol   (st_q.ctrl[g][B_POL]),
            .cval  (st_q.ctrl[g][B_VAL]),
            .pout  (st_q.pout[g]),
            .fn_in (st_q.ctrl[g][B_FN_LO +: 3]),
            .oe    (pad_oe[g]),
            .dout  (pad_do[g]),
            .fn    (fn_sel[3*g +: 3])
        );
        gpio_pin_detect u_det (
            .mode     (st_q.ctrl[g][B_DET_LO +: 4]),
            .pad_off  (st_q.ctrl[g][B_PADOFF]),
            .pad      (pad_in[g]),
            .pad_prev (st_q.inq[g]),
            .stat     (st_q.stat[g]),
            .clr      (clr[g]),
            .live     (live[g]),
            .stat_nxt (stat_nxt[g])
        );
    end

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.inq  = pad_in;
        st_d.stat = stat_nxt;
        if (bus_wr) begin
            if (!sel_bank) begin
                if (!st_q.lock[sel_idx]) begin
                    st_d.ctrl[sel_idx] = bus_wdata[CTRL_W-1:0];
                end
            end else if (sel_idx == IW'(REG_POUT)) begin
                st_d.pout = (st_q.pout & st_q.lock)
                          | (bus_wdata[NPINS-1:0] & ~st_q.lock);
            end else if (sel_idx == IW'(REG_LOCK)) begin
                st_d.lock = st_q.lock | bus_wdata[NPINS-1:0];
            end
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (!sel_bank) begin
            bus_rdata[CTRL_W-1:0] = st_q.ctrl[sel_idx];
            bus_rdata[B_PADRD]    = live[sel_idx];
        end else begin
            case (sel_idx)
                IW'(REG_PIN_IN): bus_rdata[NPINS-1:0] = live;
                IW'(REG_POUT):   bus_rdata[NPINS-1:0] = st_q.pout;
                IW'(REG_LOCK):   bus_rdata[NPINS-1:0] = st_q.lock;
                IW'(REG_STAT):   bus_rdata[NPINS-1:0] = st_q.stat;
                default:         bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= {NPINS{CTRL_RST}};
            st_q.pout <= '0;
            st_q.lock <= '0;
            st_q.stat <= '0;
            st_q.inq  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPINS-1:0][CTRL_W-1:0] ctrl_v,
    input logic [NPINS-1:0]             lock_v,
    input logic [NPINS-1:0]             pad_oe,
    input logic [NPINS-1:0]             pad_do,
    input logic [NPINS-1:0]             irq_stat
);
    AST_LOCK_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_v & $past(lock_v)) == $past(lock_v))); // R8

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_v[i][B_DIR] |-> !pad_oe[i]); // R3

        AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_v[i][B_OD] |-> !(pad_oe[i] && pad_do[i])); // R4

        AST_ALT_FN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_v[i][B_FN_LO +: 3] != 3'd0) |-> !pad_oe[i]); // R6

        AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[i] |=> $stable(ctrl_v[i])); // R9

        AST_OFF_NO_NEW_STAT: assert property (@(posedge clk) disable iff (!rst_n)
            ((ctrl_v[i][B_DET_LO +: 4] == 4'h4) && !irq_stat[i]) |=> !irq_stat[i]); // R12
    end
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_v   (ctrl_v),
    .lock_v   (lock_v),
    .pad_oe   (pad_oe),
    .pad_do   (pad_do),
    .irq_stat (irq_stat)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    localparam int NP = 32;
    localparam int AW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [NP-1:0]     pad_oe;
    logic [NP-1:0]     pad_do;
    logic [3*NP-1:0]   fn_sel;
    logic [NP-1:0]     irq_stat;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_do(pad_do), .fn_sel(fn_sel), .irq_stat(irq_stat)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = AW'(a);
        bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic det_model(input logic [3:0] m, input logic en,
                                       input logic cur, input logic prv,
                                       input logic st, input logic clrb);
        logic rise, fall, kept;
        rise = en & cur & ~prv;
        fall = en & ~cur & prv;
        kept = st & ~clrb;
        case (m)
            4'h0:    return en & ~cur;
            4'h1:    return en & cur;
            4'hD:    return kept | rise;
            4'hE:    return kept | fall;
            4'hF:    return kept | rise | fall;
            default: return kept;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  modes [7];
        modes = '{4'h0, 4'h1, 4'h4, 4'hD, 4'hE, 4'hF, 4'h7};

        pad_in = '1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int i = 0; i < NP; i++) begin
            rd(i, d);
            chk("R1 cfg", d, 32'h0000_8040);
        end
        rd(33, d); chk("R1 pout", d, 0);
        rd(34, d); chk("R1 lock", d, 0);
        rd(35, d); chk("R1 stat", d, 0);
        chk("R1 oe", pad_oe, 0);
        pad_in = '0;

        // R2: stored bits and live pad bit
        wr(5, 32'hFFFF_FFFF);
        rd(5, d); chk("R2 mask", d, 32'h0001_FFFF);
        pad_in[5] = 1'b1;
        wr(5, 32'h0000_0000);
        rd(5, d); chk("R2 live hi", d, 32'h0100_0000);
        pad_in[5] = 1'b0;
        rd(5, d); chk("R2 live lo", d, 32'h0000_0000);

        // R13: unmapped addresses read zero and ignore writes
        for (int a = 36; a < 64; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, d);
            chk("R13 unmapped", d, 0);
        end
        rd(34, d); chk("R13 lock untouched", d, 0);
        wr(33, 32'hA5A5_0F0F);
        rd(33, d); chk("R13 pout readback", d, 32'hA5A5_0F0F);

        // R3..R6: output sweep
        for (int c = 0; c < 256; c++) begin
            int p;
            logic dir, od, src, pol, cv, pb, val, eoe, edo;
            logic [2:0] fn;
            string tag;
            p   = c % NP;
            dir = c[0]; od = c[1]; src = c[2]; pol = c[3]; cv = c[4]; pb = c[5];
            case (c[7:6])
                2'd0: fn = 3'd0;
                2'd1: fn = 3'd1;
                2'd2: fn = 3'd3;
                default: fn = 3'd7;
            endcase
            wr(33, 32'(pb) << p);
            wr(p, (32'(cv) << 16) | (32'h8040) | (32'(fn) << 12) | (32'(pol) << 11)
                  | (32'(src) << 10) | (32'(dir) << 9) | (32'(od) << 8));
            val = (src ? pb : cv) ^ pol;
            eoe = 1'b0; edo = 1'b0;
            if (fn != 3'd0) tag = "R6";
            else if (!dir) tag = "R3";
            else if (od) begin tag = "R4"; eoe = ~val; end
            else begin tag = "R5"; eoe = 1'b1; edo = val; end
            #1;
            chk(tag, {29'd0, fn_sel[3*p +: 3]}, {29'd0, fn});
            chk(tag, {30'd0, pad_oe[p], pad_do[p]}, {30'd0, eoe, edo});
        end

        // R7: parallel input gated by pad disable
        for (int i = 0; i < NP; i++) wr(i, (i % 2 == 0) ? 32'h0040 : 32'h8040);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = 32'h1357_9BDF * (k + 3);
            pad_in = pat;
            rd(32, d);
            chk("R7 parin", d, pat & 32'h5555_5555);
        end
        pad_in = '0;

        // R10, R11, R12: detection sweep
        for (int mi = 0; mi < 7; mi++) begin
            for (int en = 0; en < 2; en++) begin
                int p;
                logic st, prv;
                logic [5:0] seq;
                string tag;
                p = (mi * 5 + en * 11) % NP;
                seq = 6'b100110;
                if (en == 0) tag = "R12";
                else if (modes[mi] <= 4'h1) tag = "R10";
                else if (modes[mi] >= 4'hD) tag = "R11";
                else tag = "R12";
                pad_in[p] = 1'b0;
                tick(); tick();
                wr(p, (32'(modes[mi]) << 4) | ((en == 0) ? 32'h8000 : 32'h0));
                wr(35, 32'd1 << p);
                prv = 1'b0;
                st = det_model(modes[mi], en[0], 1'b0, 1'b0, 1'b0, 1'b1);
                rd(35, d); chk(tag, {31'd0, d[p]}, {31'd0, st});
                for (int s = 0; s < 6; s++) begin
                    pad_in[p] = seq[s];
                    if (s == 3) wr(35, 32'd1 << p);
                    else tick();
                    st = det_model(modes[mi], en[0], seq[s], prv, st, s == 3);
                    prv = seq[s];
                    rd(35, d); chk(tag, {31'd0, d[p]}, {31'd0, st});
                    chk(tag, {31'd0, irq_stat[p]}, {31'd0, st});
                end
                pad_in[p] = 1'b0;
            end
        end

        // R12: off mode keeps a pending bit but adds none
        pad_in[9] = 1'b0;
        wr(9, 32'h00D0);
        tick();
        wr(35, 32'd1 << 9);
        pad_in[9] = 1'b1; tick();
        chk("R11 rise set", {31'd0, irq_stat[9]}, 1);
        wr(9, 32'h0040);
        pad_in[9] = 1'b0; tick();
        chk("R12 held in off", {31'd0, irq_stat[9]}, 1);
        wr(35, 32'd1 << 9);
        chk("R11 w1c in off", {31'd0, irq_stat[9]}, 0);
        pad_in[9] = 1'b1; tick();
        chk("R12 no new", {31'd0, irq_stat[9]}, 0);
        pad_in = '0;

        // R8, R9: lock
        wr(33, 32'h0);
        wr(7, 32'h0001_0240);
        wr(34, (32'd1 << 7) | (32'd1 << 20));
        rd(34, d); chk("R8 set", d, 32'h0010_0080);
        wr(34, 32'h0);
        rd(34, d); chk("R8 no clear", d, 32'h0010_0080);
        wr(34, 32'h0000_0001);
        rd(34, d); chk("R8 accumulate", d, 32'h0010_0081);
        wr(7, 32'h0000_8040);
        rd(7, d); chk("R9 cfg frozen", d, 32'h0001_0240);
        chk("R9 drive kept", {30'd0, pad_oe[7], pad_do[7]}, 32'h3);
        wr(8, 32'h0000_0240);
        rd(8, d); chk("R9 neighbour writes", d, 32'h0000_0240);
        wr(33, 32'hFFFF_FFFF);
        rd(33, d); chk("R9 pout masked", d, 32'hFFEF_FF7E);

        finish_run();
    end
endmodule